// File: doc/BRIEF.md
# Two-Bit Digit Constant Multiplier

This block multiplies a stream of signed data words by one fixed coefficient without a general multiplier. The coefficient is a parameter, read two bits at a time. For each 2-bit digit the block selects one of four input multiples: zero, the input, the input doubled, or the input tripled. The tripled value comes from the only adder outside the summing tree. It adds the input to a copy of itself shifted left one place, and every digit that needs it reads the same result. The selected multiples are shifted by two bit positions per digit and summed in a balanced tree, which gives the full-precision product.

The data word is two's complement. The coefficient is an unsigned magnitude. A separate parameter turns the result negative, so the block can also serve as a negative tap. One register stage follows the tripling adder and one follows the final sum. A new sample can be accepted every clock. The block suits filters with fixed taps, where each tap is one instance with its own coefficient.

Top module: `subexpr_const_mult`

## Requirements
- R1: A data word present on `din` at rising edge n appears as `din * COEF` on `product` after rising edge n+1 (two register stages, latency 2 clocks).
- R2: `din` is two's complement, and `product` is a 33-bit two's complement value. The extreme inputs -32768 and 32767, multiplied by coefficient 0xFFFF, give exact results with no wrap-around.
- R3: With `NEGATE` set to 1, `product` equals `-(din * COEF)` with the same latency.
- R4: When `rst_n` is low at a rising edge, `product` is 0 after that edge. The first output after reset is released is also 0, until the first sampled word arrives.
- R5: With `COEF` equal to 0, `product` is 0 for every input.
- R6: A digit of value 3 (bits 11) uses the shared tripled input. Coefficient 0xFFFF, where every digit is 3, gives `din * 65535`.
- R7: Digit g, which is coefficient bits [2g+1:2g], is weighted by 4 to the power g. A coefficient whose only nonzero digit is the top one (0xC000) gives `din * 49152`.
- R8: A new input word is accepted on every clock. Back-to-back different inputs each produce their own product, two clocks later, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | DATA_W (16) | Two's complement data sample |
| product | output | DATA_W+COEF_W+1 (33) | Two's complement product, registered |

## Verification
The assertions assume that `din` holds a known value at every rising edge while reset is high. Product checks look two samples back only after two edges have passed since reset was released. The stimulus drives `din` on the falling edge from the start of simulation and never leaves it undefined. A mid-run reset pulse exercises the warm-up window again. Five copies of the block share one input stream, with a mixed coefficient, all-ones, a single high digit, zero, and a negated coefficient. Together they exercise every digit value and both signs.

// File: rtl/sxm_pkg.sv
// Package: shared types and helpers for the two-bit digit constant multiplier.
// Assumes: nothing beyond the standard language.
package sxm_pkg;

    // Digit codes taken from one 2-bit group of the coefficient.
    typedef enum logic [1:0] {
        DIG_ZERO  = 2'b00,
        DIG_ONE   = 2'b01,
        DIG_TWO   = 2'b10,
        DIG_THREE = 2'b11
    } digit_e;

    // Smallest power of two not below n (n >= 1).
    function automatic int ceil_pow2(input int n);
        int p;
        p = 1;
        while (p < n) begin
            p = p * 2;
        end
        return p;
    endfunction

endpackage

// File: rtl/sxm_triple_stage.sv
// Module: first pipeline stage. Registers the sign-extended input and the
// shared tripled input (x + 2x), the only adder that the digits share.
// Assumes: din is two's complement; reset is synchronous and active low.
module sxm_triple_stage #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        din,
    output logic signed [DATA_W-1:0] x_q,
    output logic signed [DATA_W+1:0] trip_q
);
    localparam int TRIP_W = DATA_W + 2;

    logic signed [TRIP_W-1:0] x_ext;
    logic                     valid_q;

    // Sign-extend the input so the shift and the add cannot overflow.
    always_comb begin
        x_ext = {{2{din[DATA_W-1]}}, din};
    end

    // Register the input and its triple together so they stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q     <= '0;
            trip_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            x_q     <= din;
            trip_q  <= x_ext + (x_ext <<< 1);
            valid_q <= 1'b1;
        end
    end

    logic signed [TRIP_W-1:0] x_q_ext;
    // Widen the registered input for the triple check.
    always_comb begin
        x_q_ext = {{2{x_q[DATA_W-1]}}, x_q};
    end

    AST_TRIPLE_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (trip_q == x_q_ext * $signed(TRIP_W'(3)))); // R6

endmodule

// File: rtl/sxm_digit_term.sv
// Module: one coefficient digit. Selects 0, x, 2x or 3x from the registered
// multiples and weights the choice by its group position (two bits per group).
// Assumes: SHIFT + DATA_W + 2 <= OUT_W so the weighted term never overflows.
module sxm_digit_term
    import sxm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OUT_W  = 33,
    parameter int SHIFT  = 0
) (
    input  logic [1:0]               digit,
    input  logic signed [DATA_W-1:0] x_q,
    input  logic signed [DATA_W+1:0] trip_q,
    output logic signed [OUT_W-1:0]  term
);
    logic signed [OUT_W-1:0] x_wide;
    logic signed [OUT_W-1:0] trip_wide;
    logic signed [OUT_W-1:0] picked;

    // Sign-extend both multiples to the output width.
    always_comb begin
        x_wide    = {{(OUT_W-DATA_W){x_q[DATA_W-1]}}, x_q};
        trip_wide = {{(OUT_W-DATA_W-2){trip_q[DATA_W+1]}}, trip_q};
    end

    // Pick the multiple named by the digit; no adder is used here.
    always_comb begin
        case (digit_e'(digit))
            DIG_ONE:   picked = x_wide;
            DIG_TWO:   picked = x_wide <<< 1;
            DIG_THREE: picked = trip_wide;
            default:   picked = '0;
        endcase
    end

    // Weight the choice by the digit's position.
    always_comb begin
        term = picked <<< SHIFT;
    end

endmodule

// File: rtl/sxm_sum_tree.sv
// Module: balanced binary adder tree over N_IN terms, stored heap style:
// node i sums nodes 2i+1 and 2i+2, leaves sit at N_IN-1 .. 2*N_IN-2.
// Assumes: N_IN is a power of two; W is wide enough for the full sum.
module sxm_sum_tree #(
    parameter int N_IN = 8,
    parameter int W    = 33
) (
    input  logic signed [W-1:0] leaves [N_IN],
    output logic signed [W-1:0] total
);
    localparam int N_NODE = 2 * N_IN - 1;

    logic signed [W-1:0] node [N_NODE];

    // Place the leaves at the bottom of the heap.
    for (genvar i = 0; i < N_IN; i++) begin : g_leaf
        assign node[N_IN - 1 + i] = leaves[i];
    end

    // Each inner node adds its two children.
    for (genvar i = 0; i < N_IN - 1; i++) begin : g_inner
        assign node[i] = node[2*i + 1] + node[2*i + 2];
    end

    // The root carries the full sum.
    always_comb begin
        total = node[0];
    end

endmodule

// File: rtl/subexpr_const_mult.sv
// Module: top of the two-bit digit constant multiplier. Stage 1 registers x
// and the shared 3x; the digit terms and adder tree are combinational; stage 2
// registers the (optionally negated) sum. Latency is two clocks.
// Assumes: COEF is an unsigned magnitude; NEGATE gives its sign; din is
// two's complement and known at every active edge out of reset.
module subexpr_const_mult
    import sxm_pkg::*;
#(
    parameter int                DATA_W = 16,
    parameter int                COEF_W = 16,
    parameter logic [COEF_W-1:0] COEF   = 16'hA5C3,
    parameter bit                NEGATE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        din,
    output logic [DATA_W+COEF_W:0]   product
);
    localparam int OUT_W   = DATA_W + COEF_W + 1;
    localparam int NUM_GRP = (COEF_W + 1) / 2;
    localparam int TREE_N  = ceil_pow2(NUM_GRP);
    localparam int EXT_W   = 2 * NUM_GRP;
    localparam logic [EXT_W-1:0] COEF_EXT = EXT_W'(COEF);

    logic signed [DATA_W-1:0] x_q;
    logic signed [DATA_W+1:0] trip_q;
    logic signed [OUT_W-1:0]  terms [TREE_N];
    logic signed [OUT_W-1:0]  sum_total;
    logic signed [OUT_W-1:0]  prod_next;

    // Stage 1: input and shared triple.
    sxm_triple_stage #(
        .DATA_W (DATA_W)
    ) u_triple (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .x_q    (x_q),
        .trip_q (trip_q)
    );

    // One selector per coefficient digit; pad slots up to a power of two.
    for (genvar g = 0; g < TREE_N; g++) begin : g_digit
        if (g < NUM_GRP) begin : g_live
            sxm_digit_term #(
                .DATA_W (DATA_W),
                .OUT_W  (OUT_W),
                .SHIFT  (2 * g)
            ) u_term (
                .digit  (COEF_EXT[2*g +: 2]),
                .x_q    (x_q),
                .trip_q (trip_q),
                .term   (terms[g])
            );
        end else begin : g_pad
            assign terms[g] = '0;
        end
    end

    // Sum all weighted digit terms.
    sxm_sum_tree #(
        .N_IN (TREE_N),
        .W    (OUT_W)
    ) u_tree (
        .leaves (terms),
        .total  (sum_total)
    );

    // Apply the coefficient sign chosen at build time.
    if (NEGATE) begin : g_neg
        assign prod_next = -sum_total;
    end else begin : g_pos
        assign prod_next = sum_total;
    end

    // Stage 2: register the product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product <= '0;
        end else begin
            product <= prod_next;
        end
    end

    // ---------------- assertions ----------------
    logic [1:0] warm_q;
    logic       rst_seen_q;

    // Count edges since reset release, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // Remember whether the previous edge saw reset.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // Plain modular multiply used as the check value.
    function automatic logic [OUT_W-1:0] ref_prod(input logic [DATA_W-1:0] d);
        logic [OUT_W-1:0] de;
        logic [OUT_W-1:0] p;
        de = {{(OUT_W-DATA_W){d[DATA_W-1]}}, d};
        p  = de * OUT_W'(COEF);
        return NEGATE ? (~p + OUT_W'(1)) : p;
    endfunction

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst_seen_q |-> (product == '0)); // R4

    AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (product == ref_prod($past(din, 2)))); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q == 2'd2) && ($past(din, 2) != '0) && (COEF != '0))
        |-> (product[OUT_W-1] == ($past(din[DATA_W-1], 2) ^ NEGATE))); // R2

    if (COEF == '0) begin : g_zero_chk
        AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q != 2'd0) |-> (product == '0)); // R5
    end

endmodule

// File: tb/tb_subexpr_const_mult.sv
// Bench: five copies with different coefficients share one input stream.
// A behavioural model (queue of past inputs, integer multiply) predicts
// every output and is compared on every falling edge.
module tb_subexpr_const_mult;

    localparam logic [15:0] C_MIX  = 16'hA5C3;
    localparam logic [15:0] C_ONES = 16'hFFFF;
    localparam logic [15:0] C_NEG  = 16'h5B2D;
    localparam logic [15:0] C_ZERO = 16'h0000;
    localparam logic [15:0] C_TOP  = 16'hC000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = 16'h0000;
    logic [32:0] p_mix, p_ones, p_neg, p_zero, p_top;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [15:0] hist_q [$];

    always #10 clk = ~clk;

    subexpr_const_mult #(.COEF(C_MIX),  .NEGATE(1'b0)) dut    (.clk(clk), .rst_n(rst_n), .din(din), .product(p_mix));
    subexpr_const_mult #(.COEF(C_ONES), .NEGATE(1'b0)) u_ones (.clk(clk), .rst_n(rst_n), .din(din), .product(p_ones));
    subexpr_const_mult #(.COEF(C_NEG),  .NEGATE(1'b1)) u_neg  (.clk(clk), .rst_n(rst_n), .din(din), .product(p_neg));
    subexpr_const_mult #(.COEF(C_ZERO), .NEGATE(1'b0)) u_zero (.clk(clk), .rst_n(rst_n), .din(din), .product(p_zero));
    subexpr_const_mult #(.COEF(C_TOP),  .NEGATE(1'b0)) u_top  (.clk(clk), .rst_n(rst_n), .din(din), .product(p_top));

    function automatic longint model(input logic [15:0] d, input logic [15:0] c, input bit neg);
        longint e;
        e = longint'($signed(d)) * longint'(c);
        return neg ? -e : e;
    endfunction

    task automatic chk(input string tag, input string who, input logic [32:0] act, input longint exp);
        longint a;
        a = longint'($signed(act));
        checks++;
        if (a != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, who, a, exp);
        end
    endtask

    // Model history: inputs seen at each rising edge, cleared by reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist_q.delete();
        end else begin
            hist_q.push_back(din);
            if (hist_q.size() > 2) void'(hist_q.pop_front());
        end
    end

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            if (hist_q.size() < 2) begin
                chk("R4", "mix",  p_mix,  0);
                chk("R4", "ones", p_ones, 0);
                chk("R4", "neg",  p_neg,  0);
                chk("R4", "top",  p_top,  0);
                chk("R5", "zero", p_zero, 0);
            end else begin
                logic [15:0] d;
                bit ext;
                d   = hist_q[0];
                ext = (d == 16'h8000) || (d == 16'h7FFF);
                chk("R1,R8", "mix", p_mix, model(d, C_MIX, 1'b0));
                chk(ext ? "R2" : "R6", "ones", p_ones, model(d, C_ONES, 1'b0));
                chk("R3", "neg", p_neg, model(d, C_NEG, 1'b1));
                chk("R5", "zero", p_zero, 0);
                chk("R7", "top", p_top, model(d, C_TOP, 1'b0));
            end
        end
    end

    task automatic drive(input logic [15:0] v);
        @(negedge clk);
        din = v;
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Directed corners incl. the R2 extremes, changing every cycle (R8).
        drive(16'h0000); drive(16'h0001); drive(16'hFFFF); drive(16'h7FFF);
        drive(16'h8000); drive(16'h8000); drive(16'h7FFF); drive(16'h1234);
        drive(16'hEDCC); drive(16'h0002); drive(16'h5555); drive(16'hAAAA);
        // Pseudo-random run.
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr);
        end
        // Mid-run reset pulse (R4) then resume.
        @(negedge clk);
        rst_n = 1'b0;
        din = 16'h4321;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(16'h8000); drive(16'h7FFF);
        for (int i = 0; i < 50; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr);
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule